// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 or DDR3L memory channel. It brings the attached SDRAM from power-on to idle. After the controller's own synchronous reset is released, it holds the memory reset pin low for a programmed interval. It keeps clock enable low through that interval and for a further settling interval after the reset pin rises. It then raises clock enable and waits the exit-reset interval. After that it writes the four mode registers in the order MR2, MR3, MR1, MR0. Writes are spaced by the mode-register-to-mode-register interval, and the interval between MR0 and the next command is the mode-register-update interval. Finally it issues a long ZQ calibration and raises a done flag once the calibration window has passed.

All intervals are parameters counted in controller clock cycles, and all of them are timed by one shared down-counter. The four mode register opcodes come in as static inputs. On-die termination is held low for the whole sequence. Every bus cycle that is not a mode register write or the calibration command carries a NOP, so the DRAM never sees a stray command. An optional output register stage, chosen by a parameter, delays every output pin by exactly one cycle together.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is sampled low, the block drives `ddr_reset_n`=0, `ddr_cke`=0, `ddr_odt`=0, `init_done`=0, a NOP on the bus ({cs_n,ras_n,cas_n,we_n}=4'b0111) with `ddr_ba`=0 and `ddr_addr`=0. The opcode inputs have no effect on these outputs.
- R2: `ddr_reset_n` first reads high RST_HOLD_CYC+OUT_LAT cycles after the first clock edge at which `rst_n` is sampled high. OUT_LAT is 1 when REG_OUT=1 and 0 otherwise. `ddr_cke` is never high while `ddr_reset_n` is low.
- R3: `ddr_cke` rises exactly CKE_WAIT_CYC cycles after `ddr_reset_n` rises, and then stays high.
- R4: The first mode register write appears exactly XPR_CYC cycles after `ddr_cke` rises.
- R5: Exactly four mode register writes are issued, each encoded {cs_n,ras_n,cas_n,we_n}=4'b0000. Their `ddr_ba` values are, in order, 2, 3, 1, 0. `ddr_addr` carries `mr2_op`, `mr3_op`, `mr1_op`, `mr0_op` respectively.
- R6: Successive mode register writes are exactly MRD_CYC cycles apart, and the calibration command follows the MR0 write by exactly MOD_CYC cycles.
- R7: The calibration command is encoded {cs_n,ras_n,cas_n,we_n}=4'b0110 with `ddr_addr` bit 10 high, all other address bits low, and `ddr_ba`=0. It is issued once.
- R8: Every other cycle carries a NOP (4'b0111) with `ddr_ba`=0 and `ddr_addr`=0. No command other than a NOP is ever driven while `ddr_cke` is low or after `init_done` is high.
- R9: `ddr_odt` is low in every cycle.
- R10: `init_done` rises exactly ZQINIT_CYC cycles after the calibration command and stays high until `rst_n` is asserted.
- R11: Asserting `rst_n` low for one cycle at any point, including between mode register writes, forces the R1 outputs in the following cycle. After release, the whole sequence restarts with the R2–R10 timing.
- R12: Once high, `ddr_reset_n` stays high until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low controller reset; restarts the sequence |
| mr0_op | input | ROW_W | Opcode written to MR0 |
| mr1_op | input | ROW_W | Opcode written to MR1 |
| mr2_op | input | ROW_W | Opcode written to MR2 |
| mr3_op | input | ROW_W | Opcode written to MR3 |
| ddr_reset_n | output | 1 | Memory reset pin, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_odt | output | 1 | On-die termination control, held low |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank address (mode register select during writes) |
| ddr_addr | output | ROW_W | Address bus (opcode during writes, bit 10 high for calibration) |
| init_done | output | 1 | High once the memory is idle and ready |

## Verification
The hardest case to reach from the ports is a controller reset that lands in the middle of the mode register phase. There the shared counter and the write index are both part-way through. A restart must clear both, or the second pass would resume at the wrong register or with a shortened gap. The bench reaches it by watching the command bus until the first mode register write appears, then pulsing `rst_n` for a single cycle. It then re-measures every interval and every register write of the full second pass against the parameters. A different opcode pattern is used on the second pass, so that stale addresses would show.

// File: rtl/ddr3_init_pkg.sv
`timescale 1ns/1ps
package ddr3_init_pkg;

   // Sequencer phases; each timed phase owns the shared down-counter.
   typedef enum logic [2:0] {
      ST_RST      = 3'd0,
      ST_CKE_WAIT = 3'd1,
      ST_XPR      = 3'd2,
      ST_MRS      = 3'd3,
      ST_MRS_GAP  = 3'd4,
      ST_ZQCL     = 3'd5,
      ST_ZQ_WAIT  = 3'd6,
      ST_DONE     = 3'd7
   } init_state_e;

   // Command strobes as driven on the pins (all active low).
   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t PINS_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
   localparam cmd_pins_t PINS_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

   // Address bit that selects the long calibration variant.
   localparam int unsigned ZQ_LONG_BIT = 10;

   // Mode register written at each step of the write phase (mandated order).
   function automatic logic [1:0] mr_target(input logic [1:0] step);
      case (step)
         2'd0:    return 2'd2;
         2'd1:    return 2'd3;
         2'd2:    return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
`timescale 1ns/1ps
module ddr3_init_timer #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RST_VAL);
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   // R6: the sequencer may only reload the counter once the running interval has ended
   load_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> zero_o);

endmodule

// File: rtl/ddr3_init_fsm.sv
`timescale 1ns/1ps
module ddr3_init_fsm
   import ddr3_init_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned CKE_WAIT_CYC = 4,
   parameter int unsigned XPR_CYC      = 4,
   parameter int unsigned MRD_CYC      = 4,
   parameter int unsigned MOD_CYC      = 12,
   parameter int unsigned ZQINIT_CYC   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_zero_i,
   output logic             tmr_load_o,
   output logic [CNT_W-1:0] tmr_val_o,
   output init_state_e      state_o,
   output logic [1:0]       step_o
);

   // A timed phase of N cycles loads N-1; the gap phases follow a one-cycle
   // command phase, so they load N-2 to keep command-to-command spacing at N.
   localparam logic [CNT_W-1:0] LD_CKE = CNT_W'(CKE_WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] LD_XPR = CNT_W'(XPR_CYC - 1);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(MRD_CYC - 2);
   localparam logic [CNT_W-1:0] LD_MOD = CNT_W'(MOD_CYC - 2);
   localparam logic [CNT_W-1:0] LD_ZQ  = CNT_W'(ZQINIT_CYC - 2);
   localparam logic [1:0]       LAST_STEP = 2'd3;

   init_state_e state_q, state_d;
   logic [1:0]  step_q, step_d;

   always_comb begin
      state_d    = state_q;
      step_d     = step_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      case (state_q)
         ST_RST: begin
            if (tmr_zero_i) begin
               state_d    = ST_CKE_WAIT;
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_CKE;
            end
         end
         ST_CKE_WAIT: begin
            if (tmr_zero_i) begin
               state_d    = ST_XPR;
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_XPR;
            end
         end
         ST_XPR: begin
            if (tmr_zero_i) begin
               state_d = ST_MRS;
            end
         end
         ST_MRS: begin
            state_d    = ST_MRS_GAP;
            tmr_load_o = 1'b1;
            tmr_val_o  = (step_q == LAST_STEP) ? LD_MOD : LD_MRD;
         end
         ST_MRS_GAP: begin
            if (tmr_zero_i) begin
               if (step_q == LAST_STEP) begin
                  state_d = ST_ZQCL;
               end else begin
                  state_d = ST_MRS;
                  step_d  = step_q + 2'd1;
               end
            end
         end
         ST_ZQCL: begin
            state_d    = ST_ZQ_WAIT;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_ZQ;
         end
         ST_ZQ_WAIT: begin
            if (tmr_zero_i) begin
               state_d = ST_DONE;
            end
         end
         default: begin
            state_d = ST_DONE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RST;
         step_q  <= 2'd0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   assign state_o = state_q;
   assign step_o  = step_q;

   // R5: each new register write advances the write index by exactly one
   mrs_step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MRS && $past(state_q) == ST_MRS_GAP) |-> (step_q == 2'($past(step_q) + 2'd1)));

   // R6: calibration is entered only from the gap that follows the final write
   zq_after_last_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ZQCL) |-> ($past(state_q) == ST_MRS_GAP && step_q == LAST_STEP));

endmodule

// File: rtl/ddr3_init_cmd_enc.sv
`timescale 1ns/1ps
module ddr3_init_cmd_enc
   import ddr3_init_pkg::*;
#(
   parameter int unsigned ROW_W   = 16,
   parameter int unsigned BANK_W  = 3,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  init_state_e       state_i,
   input  logic [1:0]        step_i,
   input  logic [ROW_W-1:0]  mr0_op_i,
   input  logic [ROW_W-1:0]  mr1_op_i,
   input  logic [ROW_W-1:0]  mr2_op_i,
   input  logic [ROW_W-1:0]  mr3_op_i,
   output logic              reset_n_o,
   output logic              cke_o,
   output logic              odt_o,
   output cmd_pins_t         cmd_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [ROW_W-1:0]  addr_o,
   output logic              done_o
);

   logic              nxt_reset_n;
   logic              nxt_cke;
   logic              nxt_done;
   cmd_pins_t         nxt_cmd;
   logic [BANK_W-1:0] nxt_ba;
   logic [ROW_W-1:0]  nxt_addr;
   logic [1:0]        target;
   logic [ROW_W-1:0]  sel_op;

   assign target = mr_target(step_i);

   always_comb begin
      case (target)
         2'd0:    sel_op = mr0_op_i;
         2'd1:    sel_op = mr1_op_i;
         2'd2:    sel_op = mr2_op_i;
         default: sel_op = mr3_op_i;
      endcase
   end

   always_comb begin
      nxt_reset_n = (state_i != ST_RST);
      nxt_cke     = (state_i != ST_RST) && (state_i != ST_CKE_WAIT);
      nxt_done    = (state_i == ST_DONE);
      nxt_cmd     = PINS_NOP;
      nxt_ba      = '0;
      nxt_addr    = '0;
      case (state_i)
         ST_MRS: begin
            nxt_cmd  = PINS_MRS;
            nxt_ba   = BANK_W'(target);
            nxt_addr = sel_op;
         end
         ST_ZQCL: begin
            nxt_cmd  = PINS_ZQCL;
            nxt_addr = ROW_W'(1) << ZQ_LONG_BIT;
         end
         default: ;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               reset_n_o <= 1'b0;
               cke_o     <= 1'b0;
               odt_o     <= 1'b0;
               cmd_o     <= PINS_NOP;
               ba_o      <= '0;
               addr_o    <= '0;
               done_o    <= 1'b0;
            end else begin
               reset_n_o <= nxt_reset_n;
               cke_o     <= nxt_cke;
               odt_o     <= 1'b0;
               cmd_o     <= nxt_cmd;
               ba_o      <= nxt_ba;
               addr_o    <= nxt_addr;
               done_o    <= nxt_done;
            end
         end
      end else begin : g_comb_out
         assign reset_n_o = nxt_reset_n;
         assign cke_o     = nxt_cke;
         assign odt_o     = 1'b0;
         assign cmd_o     = nxt_cmd;
         assign ba_o      = nxt_ba;
         assign addr_o    = nxt_addr;
         assign done_o    = nxt_done;
      end
   endgenerate

endmodule

// File: rtl/ddr3_init_seq.sv
`timescale 1ns/1ps
module ddr3_init_seq
   import ddr3_init_pkg::*;
#(
   parameter int unsigned ROW_W        = 16,
   parameter int unsigned BANK_W       = 3,
   parameter int unsigned RST_HOLD_CYC = 50000,
   parameter int unsigned CKE_WAIT_CYC = 125000,
   parameter int unsigned XPR_CYC      = 90,
   parameter int unsigned MRD_CYC      = 4,
   parameter int unsigned MOD_CYC      = 12,
   parameter int unsigned ZQINIT_CYC   = 512,
   parameter bit          REG_OUT      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  mr0_op,
   input  logic [ROW_W-1:0]  mr1_op,
   input  logic [ROW_W-1:0]  mr2_op,
   input  logic [ROW_W-1:0]  mr3_op,
   output logic              ddr_reset_n,
   output logic              ddr_cke,
   output logic              ddr_odt,
   output logic              ddr_cs_n,
   output logic              ddr_ras_n,
   output logic              ddr_cas_n,
   output logic              ddr_we_n,
   output logic [BANK_W-1:0] ddr_ba,
   output logic [ROW_W-1:0]  ddr_addr,
   output logic              init_done
);

   localparam int unsigned MAX_A   = umax(RST_HOLD_CYC, CKE_WAIT_CYC);
   localparam int unsigned MAX_B   = umax(XPR_CYC, umax(MRD_CYC, MOD_CYC));
   localparam int unsigned MAX_CYC = umax(umax(MAX_A, MAX_B), ZQINIT_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (ROW_W < ZQ_LONG_BIT + 1) begin : g_bad_row_w
         $error("ROW_W must reach the calibration select bit");
      end
      if (BANK_W < 2) begin : g_bad_bank_w
         $error("BANK_W must address four mode registers");
      end
      if (RST_HOLD_CYC < 1 || CKE_WAIT_CYC < 1 || XPR_CYC < 1) begin : g_bad_wait
         $error("reset, clock-enable and exit intervals must be at least one cycle");
      end
      if (MRD_CYC < 2 || MOD_CYC < 2 || ZQINIT_CYC < 2) begin : g_bad_gap
         $error("command gaps must be at least two cycles");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   init_state_e      state;
   logic [1:0]       step;
   cmd_pins_t        cmd;

   ddr3_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (RST_HOLD_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   ddr3_init_fsm #(
      .CNT_W        (CNT_W),
      .CKE_WAIT_CYC (CKE_WAIT_CYC),
      .XPR_CYC      (XPR_CYC),
      .MRD_CYC      (MRD_CYC),
      .MOD_CYC      (MOD_CYC),
      .ZQINIT_CYC   (ZQINIT_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_zero_i (tmr_zero),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .state_o    (state),
      .step_o     (step)
   );

   ddr3_init_cmd_enc #(
      .ROW_W   (ROW_W),
      .BANK_W  (BANK_W),
      .REG_OUT (REG_OUT)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_i   (state),
      .step_i    (step),
      .mr0_op_i  (mr0_op),
      .mr1_op_i  (mr1_op),
      .mr2_op_i  (mr2_op),
      .mr3_op_i  (mr3_op),
      .reset_n_o (ddr_reset_n),
      .cke_o     (ddr_cke),
      .odt_o     (ddr_odt),
      .cmd_o     (cmd),
      .ba_o      (ddr_ba),
      .addr_o    (ddr_addr),
      .done_o    (init_done)
   );

   assign ddr_cs_n  = cmd.cs_n;
   assign ddr_ras_n = cmd.ras_n;
   assign ddr_cas_n = cmd.cas_n;
   assign ddr_we_n  = cmd.we_n;

   // R2
   cke_low_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ddr_reset_n |-> !ddr_cke);

   // R3
   cke_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ddr_cke |=> ddr_cke);

   // R12
   reset_pin_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ddr_reset_n |=> ddr_reset_n);

   // R8
   cmd_only_when_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ddr_cs_n && !(ddr_ras_n && ddr_cas_n && ddr_we_n)) |-> (ddr_cke && ddr_reset_n && !init_done));

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

endmodule

// File: tb/ddr3_init_seq_bench.sv
`timescale 1ns/1ps
module ddr3_init_seq_bench;

   localparam int unsigned ROW_W   = 16;
   localparam int unsigned BANK_W  = 3;
   localparam int unsigned T_RST   = 12;
   localparam int unsigned T_CKE   = 15;
   localparam int unsigned T_XPR   = 7;
   localparam int unsigned T_MRD   = 4;
   localparam int unsigned T_MOD   = 9;
   localparam int unsigned T_ZQ    = 16;
   localparam bit          REG_OUT = 1'b1;
   localparam int          LAT     = REG_OUT ? 1 : 0;
   localparam int          SPAN    = T_RST + T_CKE + T_XPR + 3*T_MRD + T_MOD + T_ZQ + LAT + 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ROW_W-1:0] op0 = '0, op1 = '0, op2 = '0, op3 = '0;
   logic ddr_reset_n, ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
   logic [BANK_W-1:0] ddr_ba;
   logic [ROW_W-1:0]  ddr_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ddr3_init_seq #(
      .ROW_W (ROW_W), .BANK_W (BANK_W),
      .RST_HOLD_CYC (T_RST), .CKE_WAIT_CYC (T_CKE), .XPR_CYC (T_XPR),
      .MRD_CYC (T_MRD), .MOD_CYC (T_MOD), .ZQINIT_CYC (T_ZQ), .REG_OUT (REG_OUT)
   ) u_ddr3_init_seq (
      .clk (clk), .rst_n (rst_n),
      .mr0_op (op0), .mr1_op (op1), .mr2_op (op2), .mr3_op (op3),
      .ddr_reset_n (ddr_reset_n), .ddr_cke (ddr_cke), .ddr_odt (ddr_odt),
      .ddr_cs_n (ddr_cs_n), .ddr_ras_n (ddr_ras_n), .ddr_cas_n (ddr_cas_n), .ddr_we_n (ddr_we_n),
      .ddr_ba (ddr_ba), .ddr_addr (ddr_addr), .init_done (init_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] bus_cmd();
      return {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
   endfunction

   task automatic check_idle_outputs(input string req);
      chk(ddr_reset_n == 1'b0, req, "reset pin", ddr_reset_n, 0);
      chk(ddr_cke == 1'b0, req, "cke", ddr_cke, 0);
      chk(ddr_odt == 1'b0, req, "odt", ddr_odt, 0);
      chk(init_done == 1'b0, req, "done", init_done, 0);
      chk(bus_cmd() == 4'b0111, req, "bus command", bus_cmd(), 4'b0111);
      chk(ddr_ba == '0 && ddr_addr == '0, req, "ba/addr", {ddr_ba, ddr_addr}, 0);
   endtask

   // Assumes rst_n was set high at the current negedge; observes a full pass.
   task automatic observe_sequence(input string tag);
      int t_rst = -1, t_cke = -1, t_zq = -1, t_done = -1, n_mrs = 0, extra = 0, bad_nop = 0;
      int t_mrs[4];
      int ba_mrs[4];
      longint a_mrs[4];
      longint zq_addr = 0;
      int zq_ba = 0;
      bit rst_fell = 0, cke_fell = 0, cke_early = 0, done_fell = 0, odt_seen = 0;
      longint exp_op[4];
      int exp_ba[4];
      int e_rst, e_cke, e_mrs0;
      exp_op[0] = op2; exp_op[1] = op3; exp_op[2] = op1; exp_op[3] = op0;
      exp_ba[0] = 2;   exp_ba[1] = 3;   exp_ba[2] = 1;   exp_ba[3] = 0;
      for (int i = 0; i < 4; i++) begin
         t_mrs[i] = -1; ba_mrs[i] = -1; a_mrs[i] = -1;
      end
      for (int k = 0; k < SPAN; k++) begin
         @(negedge clk);
         if (ddr_reset_n && t_rst < 0) t_rst = k;
         if (!ddr_reset_n && t_rst >= 0) rst_fell = 1;
         if (ddr_cke && !ddr_reset_n) cke_early = 1;
         if (ddr_cke && t_cke < 0) t_cke = k;
         if (!ddr_cke && t_cke >= 0) cke_fell = 1;
         if (ddr_odt) odt_seen = 1;
         if (init_done && t_done < 0) t_done = k;
         if (!init_done && t_done >= 0) done_fell = 1;
         case (bus_cmd())
            4'b0000: begin
               if (n_mrs < 4) begin
                  t_mrs[n_mrs] = k; ba_mrs[n_mrs] = int'(ddr_ba); a_mrs[n_mrs] = ddr_addr;
                  n_mrs++;
               end else extra++;
            end
            4'b0110: begin
               if (t_zq < 0) begin
                  t_zq = k; zq_addr = ddr_addr; zq_ba = int'(ddr_ba);
               end else extra++;
            end
            4'b0111: if (ddr_ba != '0 || ddr_addr != '0) bad_nop++;
            default: bad_nop++;
         endcase
      end
      e_rst  = T_RST + LAT;
      e_cke  = e_rst + T_CKE;
      e_mrs0 = e_cke + T_XPR;
      chk(t_rst == e_rst, "R2", {tag, " reset pin release cycle"}, t_rst, e_rst);
      chk(!cke_early, "R2", {tag, " cke high while reset pin low"}, cke_early, 0);
      chk(!rst_fell, "R12", {tag, " reset pin fell again"}, rst_fell, 0);
      chk(t_cke == e_cke, "R3", {tag, " cke rise cycle"}, t_cke, e_cke);
      chk(!cke_fell, "R3", {tag, " cke fell after rise"}, cke_fell, 0);
      chk(t_mrs[0] == e_mrs0, "R4", {tag, " first mode write cycle"}, t_mrs[0], e_mrs0);
      chk(n_mrs == 4, "R5", {tag, " mode write count"}, n_mrs, 4);
      for (int i = 0; i < 4; i++) begin
         chk(ba_mrs[i] == exp_ba[i], "R5", {tag, " mode write bank"}, ba_mrs[i], exp_ba[i]);
         chk(a_mrs[i] == exp_op[i], "R5", {tag, " mode write opcode"}, a_mrs[i], exp_op[i]);
      end
      for (int i = 1; i < 4; i++) begin
         chk(t_mrs[i] - t_mrs[i-1] == int'(T_MRD), "R6", {tag, " mode write spacing"},
             t_mrs[i] - t_mrs[i-1], T_MRD);
      end
      chk(t_zq - t_mrs[3] == int'(T_MOD), "R6", {tag, " MR0 to calibration gap"}, t_zq - t_mrs[3], T_MOD);
      chk(zq_addr == (longint'(1) << 10), "R7", {tag, " calibration address"}, zq_addr, 1 << 10);
      chk(zq_ba == 0, "R7", {tag, " calibration bank"}, zq_ba, 0);
      chk(bad_nop == 0, "R8", {tag, " non-NOP filler cycles"}, bad_nop, 0);
      chk(extra == 0, "R8", {tag, " surplus commands"}, extra, 0);
      chk(!odt_seen, "R9", {tag, " odt high seen"}, odt_seen, 0);
      chk(t_done - t_zq == int'(T_ZQ), "R10", {tag, " calibration to done"}, t_done - t_zq, T_ZQ);
      chk(!done_fell, "R10", {tag, " done dropped"}, done_fell, 0);
   endtask

   task automatic test_reset_state();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_idle_outputs("R1");
      op0 = 16'hFFFF; op1 = 16'hA5A5; op2 = 16'h1234; op3 = 16'h8001;
      repeat (2) @(negedge clk);
      chk(ddr_addr == '0 && bus_cmd() == 4'b0111, "R1", "opcodes leak during reset",
          ddr_addr, 0);
   endtask

   task automatic test_sequence(input string tag, input logic [ROW_W-1:0] a,
                                input logic [ROW_W-1:0] b, input logic [ROW_W-1:0] c,
                                input logic [ROW_W-1:0] d, input int hold);
      op0 = a; op1 = b; op2 = c; op3 = d;
      rst_n = 1'b0;
      repeat (hold) @(negedge clk);
      rst_n = 1'b1;
      observe_sequence(tag);
   endtask

   task automatic test_restart();
      int guard = 0;
      op0 = 16'h0D70; op1 = 16'h0044; op2 = 16'h0018; op3 = 16'h0004;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      while (bus_cmd() != 4'b0000 && guard < SPAN) begin
         @(negedge clk); guard++;
      end
      chk(bus_cmd() == 4'b0000, "R11", "reached first mode write before restart", bus_cmd(), 0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle_outputs("R11");
      op0 = 16'h7E81; op1 = 16'h3C00; op2 = 16'h00FF; op3 = 16'hC003;
      rst_n = 1'b1;
      observe_sequence("R11 restart");
   endtask

   initial begin
      test_reset_state();
      test_sequence("pattern A", 16'h1B70, 16'h0006, 16'h0208, 16'h0000, 2);
      test_sequence("pattern B", 16'hFFFF, 16'h5555, 16'hAAAA, 16'h8421, 1);
      test_restart();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", 100000, SPAN * 4);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule